// File: doc/BRIEF.md
# Multicycle Execute Stall Controller

This block controls the pipeline while an operation sits in the execute stage for more than one cycle. Multiply, divide and a data-cache miss are the three such operations. While one of them is active, the controller freezes the execute stage and every stage in front of it, so those stages keep their registers. It also sends bubbles into every stage behind execute, so work already past execute keeps flowing out of the pipe. There is no global stall.

A small control word stays in the execute stage. It holds the operation kind and a down-counter, and it steps the operation through its cycles. Multiply and divide are modelled as fixed countdowns set by parameters. A miss waits until memory reports ready. In the final cycle all hold and bubble enables drop, and a done strobe tells the datapath that the result moves on to the memory stage with its destination register and write enable.

A stage that receives a bubble enable clears its valid, register-write and memory-write bits, so the bubble has no side effects. Instructions enter execute in order, and each kind of work happens in one fixed stage, so there are no hazards between memory operations.

Top module: `mc_stall_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, `hold`, `bubble` and `done` are all zero.
- R2: Stage indices run from 0 (front of the pipe) to NSTG-1, and execute is index EX_IDX. Suppose `start` is high in cycle t with `op_kind` = 2'b00 (multiply) and the execute stage valid. Then the operation is busy in cycles t+1 to t+MUL_CYC-1, and `done` is high in cycle t+MUL_CYC.
- R3: A start with `op_kind` = 2'b01 (divide) follows the same timing as R2 but uses DIV_CYC cycles.
- R4: A start with `op_kind` = 2'b10 (cache miss) makes the operation busy from cycle t+1. It stays busy until `mem_ready` is sampled high during a busy cycle c, and `done` is then high in cycle c+1.
- R5: In every busy cycle, `hold` is 1 exactly on stages 0 to EX_IDX and `bubble` is 1 exactly on stages EX_IDX+1 to NSTG-1. No stage ever has both bits set.
- R6: `done` lasts a single cycle. While `done` is high, every `hold` and `bubble` bit is zero.
- R7: A `start` that arrives while an operation is busy is ignored. The timing of the running operation does not change.
- R8: A `start` is ignored when `stage_vld[EX_IDX]` is 0, and also when `op_kind` = 2'b11.
- R9: A `start` accepted in the cycle where `done` is high begins the next operation at once, so the next cycle is already busy.
- R10: With no accepted start, the block stays idle and all outputs stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | A multicycle operation is entering execute |
| op_kind | input | 2 | 00 multiply, 01 divide, 10 cache miss, 11 none |
| stage_vld | input | NSTG | Valid bit of each pipeline stage |
| mem_ready | input | 1 | Memory has answered the miss |
| hold | output | NSTG | Per-stage register hold enable |
| bubble | output | NSTG | Per-stage bubble-insert enable |
| done | output | 1 | Final cycle of the operation |

## Verification
The hardest case to reach is a new start that lands exactly in the one-cycle final state, where a missed edge would either add an idle cycle or lose the operation. The stimulus reaches it by following the expected state each cycle and firing a divide at the moment a multiply reports done. Long random runs then mix in starts during busy cycles, an invalid execute stage, the "none" code and late memory-ready pulses.

// File: rtl/mc_stall_pkg.sv
package mc_stall_pkg;
    typedef enum logic [1:0] {
        OP_MUL  = 2'b00,
        OP_DIV  = 2'b01,
        OP_MISS = 2'b10,
        OP_NONE = 2'b11
    } mc_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STEP,
        ST_WAIT,
        ST_LAST
    } mc_state_e;
endpackage

// File: rtl/mc_step_ctr.sv
module mc_step_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/mc_stage_mask.sv
module mc_stage_mask #(
    parameter int NSTG   = 5,
    parameter int EX_IDX = 2
) (
    input  logic            busy,
    output logic [NSTG-1:0] hold,
    output logic [NSTG-1:0] bubble
);
    for (genvar k = 0; k < NSTG; k++) begin : g_stage
        if (k <= EX_IDX) begin : g_up
            assign hold[k]   = busy;
            assign bubble[k] = 1'b0;
        end else begin : g_down
            assign hold[k]   = 1'b0;
            assign bubble[k] = busy;
        end
    end
endmodule

// File: rtl/mc_stall_ctrl.sv
module mc_stall_ctrl
    import mc_stall_pkg::*;
#(
    parameter int NSTG    = 5,
    parameter int EX_IDX  = 2,
    parameter int MUL_CYC = 4,
    parameter int DIV_CYC = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op_kind,
    input  logic [NSTG-1:0] stage_vld,
    input  logic            mem_ready,
    output logic [NSTG-1:0] hold,
    output logic [NSTG-1:0] bubble,
    output logic            done
);
    localparam int MAX_CYC = (MUL_CYC > DIV_CYC) ? MUL_CYC : DIV_CYC;
    localparam int CW      = $clog2(MAX_CYC) + 1;
    localparam logic [CW-1:0] MUL_LD = CW'(MUL_CYC - 2);
    localparam logic [CW-1:0] DIV_LD = CW'(DIV_CYC - 2);

    mc_state_e   st_q, st_d;
    mc_op_e      kind;
    logic        accept, ctr_load, ctr_dec, ctr_zero, busy;
    logic [CW-1:0] ctr_val;

    assign kind   = mc_op_e'(op_kind);
    assign accept = start && stage_vld[EX_IDX] && (kind != OP_NONE)
                    && (st_q == ST_IDLE || st_q == ST_LAST);

    // next state
    always_comb begin
        st_d     = st_q;
        ctr_load = 1'b0;
        ctr_dec  = 1'b0;
        ctr_val  = MUL_LD;
        unique case (st_q)
            ST_IDLE, ST_LAST: begin
                st_d = ST_IDLE;
                if (accept) begin
                    unique case (kind)
                        OP_MUL:  begin st_d = ST_STEP; ctr_load = 1'b1; ctr_val = MUL_LD; end
                        OP_DIV:  begin st_d = ST_STEP; ctr_load = 1'b1; ctr_val = DIV_LD; end
                        OP_MISS: st_d = ST_WAIT;
                        OP_NONE: st_d = ST_IDLE;
                    endcase
                end
            end
            ST_STEP: begin
                if (ctr_zero) st_d = ST_LAST;
                else          ctr_dec = 1'b1;
            end
            ST_WAIT: begin
                if (mem_ready) st_d = ST_LAST;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (st_q)
            ST_IDLE:          ;
            ST_STEP, ST_WAIT: busy = 1'b1;
            ST_LAST:          done = 1'b1;
        endcase
    end

    mc_step_ctr #(.W(CW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .dec      (ctr_dec),
        .zero     (ctr_zero)
    );

    mc_stage_mask #(.NSTG(NSTG), .EX_IDX(EX_IDX)) u_mask (
        .busy   (busy),
        .hold   (hold),
        .bubble (bubble)
    );
endmodule

// File: rtl/mc_stall_chk.sv
module mc_stall_chk #(
    parameter int NSTG   = 5,
    parameter int EX_IDX = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [1:0]      op_kind,
    input logic [NSTG-1:0] stage_vld,
    input logic            mem_ready,
    input logic [NSTG-1:0] hold,
    input logic [NSTG-1:0] bubble,
    input logic            done
);
    // R5
    no_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold & bubble) == '0);

    // R5
    freeze_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hold) == (|bubble));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hold == '0 && bubble == '0));

    // R9
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start && stage_vld[EX_IDX] && op_kind != 2'b11) |=> hold[0]);

    // R8
    bad_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|hold) && !stage_vld[EX_IDX]) |=> !(|hold));

    // R10
    stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|hold) && !start) |=> !(|hold));

    // R4
    miss_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|hold) && done) |-> 1'b0);
endmodule

bind mc_stall_ctrl mc_stall_chk #(.NSTG(NSTG), .EX_IDX(EX_IDX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_kind   (op_kind),
    .stage_vld (stage_vld),
    .mem_ready (mem_ready),
    .hold      (hold),
    .bubble    (bubble),
    .done      (done)
);

// File: tb/sim_mc_stall_ctrl.sv
module sim_mc_stall_ctrl;
    localparam int NSTG = 5;
    localparam int EX   = 2;
    localparam int MUL  = 4;
    localparam int DIV  = 12;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            start;
    logic [1:0]      op_kind;
    logic [NSTG-1:0] stage_vld;
    logic            mem_ready;
    logic [NSTG-1:0] hold, bubble;
    logic            done;

    always #5 clk = ~clk;

    mc_stall_ctrl #(.NSTG(NSTG), .EX_IDX(EX), .MUL_CYC(MUL), .DIV_CYC(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
        .stage_vld(stage_vld), .mem_ready(mem_ready),
        .hold(hold), .bubble(bubble), .done(done)
    );

    int    n_cmp = 0, n_bad = 0;
    int    m_st = 0, m_rem = 0, m_kind = 0;
    string phase = "";
    bit    finished = 0;

    function automatic logic [NSTG-1:0] exp_hold(int st);
        logic [NSTG-1:0] m = '0;
        for (int k = 0; k <= EX; k++) m[k] = (st == 1 || st == 2);
        return m;
    endfunction

    function automatic logic [NSTG-1:0] exp_bub(int st);
        logic [NSTG-1:0] m = '0;
        for (int k = EX + 1; k < NSTG; k++) m[k] = (st == 1 || st == 2);
        return m;
    endfunction

    function automatic string auto_tag(int st, int kind);
        if (st == 3) return "R6";
        if (st == 0) return "R10";
        if (kind == 0) return "R2/R5";
        if (kind == 1) return "R3/R5";
        return "R4/R5";
    endfunction

    task automatic check_outs();
        logic [NSTG-1:0] eh = exp_hold(m_st);
        logic [NSTG-1:0] eb = exp_bub(m_st);
        logic            ed = (m_st == 3);
        string tag = (phase != "") ? phase : auto_tag(m_st, m_kind);
        n_cmp++;
        if (hold !== eh || bubble !== eb || done !== ed) begin
            n_bad++;
            $display("FAIL %s: hold=%b bubble=%b done=%b expected hold=%b bubble=%b done=%b",
                     tag, hold, bubble, done, eh, eb, ed);
        end
    endtask

    task automatic model_step();
        if (!rst_n) begin
            m_st = 0;
            return;
        end
        case (m_st)
            0, 3: begin
                if (start && stage_vld[EX] && op_kind != 2'b11) begin
                    m_kind = int'(op_kind);
                    if (op_kind == 2'b10) m_st = 2;
                    else begin
                        m_rem = ((op_kind == 2'b00) ? MUL : DIV) - 1;
                        m_st  = 1;
                    end
                end else m_st = 0;
            end
            1: if (m_rem == 1) m_st = 3; else m_rem--;
            2: if (mem_ready) m_st = 3;
            default: m_st = 0;
        endcase
    endtask

    task automatic tick(input logic s, input logic [1:0] k,
                        input logic [NSTG-1:0] v, input logic r);
        start = s; op_kind = k; stage_vld = v; mem_ready = r;
        model_step();
        @(negedge clk);
        check_outs();
    endtask

    task automatic run_out();
        for (int i = 0; i < 40 && m_st != 0; i++) tick(0, 2'b00, '1, 0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7));
        rst_n = 0; start = 0; op_kind = 0; stage_vld = '0; mem_ready = 0;
        phase = "R1 reset";
        @(negedge clk); check_outs();
        tick(1, 2'b00, '1, 1);            // ignored during reset
        rst_n = 1;
        tick(0, 2'b00, '1, 0);
        phase = "";

        // R2 multiply
        tick(1, 2'b00, '1, 0); run_out();
        // R3 divide
        tick(1, 2'b01, '1, 0); run_out();
        // R4 miss with late ready
        tick(1, 2'b10, '1, 1);            // ready in start cycle does not end it
        for (int i = 0; i < 5; i++) tick(0, 2'b00, '1, 0);
        tick(0, 2'b00, '1, 1);
        run_out();

        // R9 start in the done cycle
        phase = "R9 back-to-back";
        tick(1, 2'b00, '1, 0);
        while (m_st != 3) tick(0, 2'b00, '1, 0);
        tick(1, 2'b01, '1, 0);
        run_out();

        // R7 start while busy
        phase = "R7 start while busy";
        tick(1, 2'b01, '1, 0);
        for (int i = 0; i < 6; i++) tick(1, 2'b00, '1, 0);
        run_out();

        // R8 invalid execute stage and none code
        phase = "R8 ignored start";
        tick(1, 2'b00, 5'b11011, 0);
        tick(1, 2'b11, '1, 0);
        tick(0, 2'b00, '1, 0);

        // R10 idle
        phase = "R10 idle";
        for (int i = 0; i < 4; i++) tick(0, 2'b10, '1, 1);

        // random mix
        phase = "";
        for (int i = 0; i < 3000; i++) begin
            logic s = ($urandom % 3) == 0;
            logic [1:0] k = 2'($urandom % 4);
            logic [NSTG-1:0] v = NSTG'($urandom);
            logic r = ($urandom % 4) == 0;
            if (($urandom % 4) != 0) v[EX] = 1'b1;
            tick(s, k, v, r);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule